// File: doc/BRIEF.md
# Cycle Timing Pulse Generator

This block paces a cyclic real-time fieldbus node. Each communication cycle starts either on an active edge of an external cycle-sync input or when an internal period counter expires. From that instant it counts elapsed time in microseconds. The microsecond tick comes from a prescaler that divides the master clock (12 to 20 MHz in the target system) by a programmable amount. Cycle lengths therefore span from tens of microseconds up to about 65 ms.

Within every cycle the block drives two timing outputs. The first is a single control pulse with programmable start time, width and polarity. The second is a burst of one-microsecond pulses with programmable first-pulse time, pulse count, spacing and polarity. All timing settings are captured as a set at the start of each cycle. Software can therefore rewrite them at any moment without tearing the cycle in progress.

Top module: `cycle_timer_top`

## Requirements
- R1: The microsecond tick occurs once every `cfg_us_div`+1 master clocks. The divisor is captured at cycle start. At every cycle start both the prescaler phase and the microsecond count restart at zero, so the count during the k-th clock of a cycle (k=0 at the cycle start) is floor(k/(`cfg_us_div`+1)).
- R2: With `cfg_ext_sync`=1, each active edge of `sync_in` starts a cycle (rising when `cfg_sync_rise`=1, falling when 0). `cycle_start` is high for one clock, in the third clock after the input changes (two synchroniser flops plus one edge register). Inactive edges start nothing, and no internal wrap occurs.
- R3: With `cfg_ext_sync`=0, cycles repeat every `cfg_period`×(`cfg_us_div`+1) master clocks, using the period value captured at cycle start (period of 1 or more).
- R4: `ctl_clk` is active while start ≤ u < start+width, where u is the microsecond count of the previous clock (one register stage). A width of 0 gives no pulse.
- R5: `cfg_ctl_low`=0 makes `ctl_clk` active high and idle low; 1 makes it active low and idle high.
- R6: `div_clk` is active for the whole microsecond u whenever u = start + j×interval for j = 0 to count−1, again lagging the count by one clock. An interval of 0 acts as 1.
- R7: `cfg_div_low` sets the active level of `div_clk` in the same way as R5; with no pulse due it rests at its idle level.
- R8: A new cycle start cuts short a control pulse still in progress and cancels every burst pulse not yet emitted.
- R9: Changes to any timing setting made during a cycle have no effect until the next cycle start.
- R10: During reset all three outputs are low. The first clock after reset is a cycle start that captures the settings present then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Asynchronous external cycle-sync input |
| cfg_ext_sync | input | 1 | 1: cycles follow sync_in; 0: internal period |
| cfg_sync_rise | input | 1 | 1: rising edge of sync_in is active; 0: falling |
| cfg_us_div | input | DIV_W | Master clocks per microsecond minus one |
| cfg_period | input | TIME_W | Internal cycle length in microseconds |
| cfg_ctl_start | input | TIME_W | Control pulse start, microseconds |
| cfg_ctl_width | input | TIME_W | Control pulse width, microseconds |
| cfg_ctl_low | input | 1 | Control pulse active low when 1 |
| cfg_div_start | input | TIME_W | First burst pulse time, microseconds |
| cfg_div_count | input | CNT_W | Burst pulses per cycle |
| cfg_div_interval | input | TIME_W | Burst pulse spacing, microseconds |
| cfg_div_low | input | 1 | Burst pulses active low when 1 |
| cycle_start | output | 1 | One-clock pulse at each cycle start |
| ctl_clk | output | 1 | Control pulse output |
| div_clk | output | 1 | Burst pulse output |

## Verification
The bench aims at the points where a pulse window meets a cycle boundary. These include a control pulse wider than the remaining cycle and a burst whose tail runs past the next start. A design that failed to reset its schedulers would leak pulses into the next cycle. It also rewrites the settings mid-cycle at random moments, which catches a design that applies them at once rather than at the next start. The directed cases cover an interval of 0, a width of 0 and a divisor of 0. These catch a design that divides by zero, stalls the burst, or emits a sliver. For external sync, both polarities are driven with edges a few clocks apart, so the bench would see a miscounted synchroniser depth or a response to the inactive edge.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } cyc_src_e;

  // Output level for a pulse: active_low inverts the raw window.
  function automatic logic out_level(input logic active, input logic active_low);
    return active ^ active_low;
  endfunction

endpackage

// File: rtl/cyc_sync_edge.sv
module cyc_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic rise_active,
  output logic edge_o
);
  localparam int LAST = SYNC_STAGES;

  // Stages 0..LAST-1 synchronise, stage LAST holds the previous level.
  logic [LAST:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[LAST-1:0], sync_in};
  end

  logic cur_lvl, prev_lvl;
  assign cur_lvl  = sr[LAST-1];
  assign prev_lvl = sr[LAST];

  assign edge_o = rise_active ? (cur_lvl & ~prev_lvl) : (~cur_lvl & prev_lvl);

endmodule

// File: rtl/cyc_timebase.sv
module cyc_timebase #(
  parameter int DIV_W  = 5,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_go,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [TIME_W-1:0] cfg_period,
  output logic              tick,
  output logic [TIME_W-1:0] us_cnt,
  output logic              wrap
);
  localparam logic [TIME_W-1:0] US_MAX = '1;

  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  pre_cnt;
  logic [TIME_W-1:0] period_q;

  assign tick = (pre_cnt == div_q);
  assign wrap = tick && (({1'b0, us_cnt} + 1'b1) == {1'b0, period_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      period_q <= '0;
      pre_cnt  <= '0;
      us_cnt   <= '0;
    end else if (cyc_go) begin
      div_q    <= cfg_div;
      period_q <= cfg_period;
      pre_cnt  <= '0;
      us_cnt   <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      if (us_cnt != US_MAX) us_cnt <= us_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cyc_ctl_pulse.sv
module cyc_ctl_pulse
  import cyc_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_go,
  input  logic [TIME_W-1:0] us_cnt,
  input  logic [TIME_W-1:0] cfg_start,
  input  logic [TIME_W-1:0] cfg_width,
  input  logic              cfg_low,
  output logic              pulse_o,
  output logic              low_q
);
  logic [TIME_W-1:0] start_q, width_q;
  logic [TIME_W:0]   stop_pt;
  logic              in_win;

  assign stop_pt = {1'b0, start_q} + {1'b0, width_q};
  assign in_win  = ({1'b0, us_cnt} >= {1'b0, start_q}) && ({1'b0, us_cnt} < stop_pt);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      width_q <= '0;
      low_q   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= out_level(in_win, low_q);
      if (cyc_go) begin
        start_q <= cfg_start;
        width_q <= cfg_width;
        low_q   <= cfg_low;
      end
    end
  end

endmodule

// File: rtl/cyc_div_pulse.sv
module cyc_div_pulse
  import cyc_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_go,
  input  logic              tick,
  input  logic [TIME_W-1:0] us_cnt,
  input  logic [TIME_W-1:0] cfg_start,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [TIME_W-1:0] cfg_interval,
  input  logic              cfg_low,
  output logic              pulse_o,
  output logic              low_q,
  output logic              idle_o
);
  logic [TIME_W:0]   next_at;
  logic [CNT_W-1:0]  left_q;
  logic [TIME_W-1:0] step_q;
  logic              hit;

  assign hit    = (left_q != '0) && ({1'b0, us_cnt} == next_at);
  assign idle_o = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      next_at <= '0;
      left_q  <= '0;
      step_q  <= '0;
      low_q   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= out_level(hit, low_q);
      if (cyc_go) begin
        next_at <= {1'b0, cfg_start};
        left_q  <= cfg_count;
        step_q  <= (cfg_interval == '0) ? TIME_W'(1) : cfg_interval;
        low_q   <= cfg_low;
      end else if (tick && hit) begin
        next_at <= next_at + {1'b0, step_q};
        left_q  <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/cycle_timer_top.sv
module cycle_timer_top
  import cyc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 5,
  parameter int TIME_W      = 16,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  input  logic              cfg_ext_sync,
  input  logic              cfg_sync_rise,
  input  logic [DIV_W-1:0]  cfg_us_div,
  input  logic [TIME_W-1:0] cfg_period,
  input  logic [TIME_W-1:0] cfg_ctl_start,
  input  logic [TIME_W-1:0] cfg_ctl_width,
  input  logic              cfg_ctl_low,
  input  logic [TIME_W-1:0] cfg_div_start,
  input  logic [CNT_W-1:0]  cfg_div_count,
  input  logic [TIME_W-1:0] cfg_div_interval,
  input  logic              cfg_div_low,
  output logic              cycle_start,
  output logic              ctl_clk,
  output logic              div_clk
);
  logic              sync_edge;
  logic              tick;
  logic              wrap;
  logic [TIME_W-1:0] us_cnt;
  logic              first_q;
  logic              cyc_go;
  logic              ctl_low_q;
  logic              div_low_q;
  logic              div_idle;
  cyc_src_e          src;

  assign src    = cyc_src_e'(cfg_ext_sync);
  assign cyc_go = first_q | ((src == SRC_EXTERNAL) ? sync_edge : wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q     <= 1'b1;
      cycle_start <= 1'b0;
    end else begin
      first_q     <= 1'b0;
      cycle_start <= cyc_go;
    end
  end

  cyc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sync_in(sync_in),
    .rise_active(cfg_sync_rise), .edge_o(sync_edge)
  );

  cyc_timebase #(.DIV_W(DIV_W), .TIME_W(TIME_W)) u_tb (
    .clk(clk), .rst(rst), .cyc_go(cyc_go), .cfg_div(cfg_us_div),
    .cfg_period(cfg_period), .tick(tick), .us_cnt(us_cnt), .wrap(wrap)
  );

  cyc_ctl_pulse #(.TIME_W(TIME_W)) u_ctl (
    .clk(clk), .rst(rst), .cyc_go(cyc_go), .us_cnt(us_cnt),
    .cfg_start(cfg_ctl_start), .cfg_width(cfg_ctl_width), .cfg_low(cfg_ctl_low),
    .pulse_o(ctl_clk), .low_q(ctl_low_q)
  );

  cyc_div_pulse #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .cyc_go(cyc_go), .tick(tick), .us_cnt(us_cnt),
    .cfg_start(cfg_div_start), .cfg_count(cfg_div_count),
    .cfg_interval(cfg_div_interval), .cfg_low(cfg_div_low),
    .pulse_o(div_clk), .low_q(div_low_q), .idle_o(div_idle)
  );

endmodule

// File: rtl/cycle_timer_chk.sv
module cycle_timer_chk #(
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_ext_sync,
  input logic              sync_edge,
  input logic              tick,
  input logic              cyc_go,
  input logic [TIME_W-1:0] us_cnt,
  input logic              cycle_start,
  input logic              ctl_low_q,
  input logic              div_low_q,
  input logic              div_idle,
  input logic              div_clk
);
  localparam logic [TIME_W-1:0] US_MAX = '1;

  // R1: a cycle start clears the microsecond count and raises cycle_start
  p_restart_r1: assert property (@(posedge clk) disable iff (rst)
    (!rst && cyc_go) |=> (us_cnt == '0 && cycle_start));

  // R1: each tick inside a cycle advances the count by exactly one
  p_count_r1: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cyc_go && tick && us_cnt != US_MAX) |=> (us_cnt == $past(us_cnt) + 1'b1));

  // R2: an active sync edge in external mode starts a cycle
  p_ext_sync_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && cfg_ext_sync && sync_edge) |=> cycle_start);

  // R9: captured polarities change only at a cycle start
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cycle_start) |-> ($stable(ctl_low_q) && $stable(div_low_q)));

  // R7: with no burst pulse left, div_clk rests at its idle level
  p_div_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!rst && div_idle) |=> (div_clk == $past(div_low_q)));

endmodule

bind cycle_timer_top cycle_timer_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_ext_sync(cfg_ext_sync), .sync_edge(sync_edge),
  .tick(tick), .cyc_go(cyc_go), .us_cnt(us_cnt), .cycle_start(cycle_start),
  .ctl_low_q(ctl_low_q), .div_low_q(div_low_q), .div_idle(div_idle),
  .div_clk(div_clk)
);

// File: tb/sim_cycle_timer_top.sv
module sim_cycle_timer_top;
  localparam int DIV_W  = 5;
  localparam int TIME_W = 16;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0;
  logic cfg_ext_sync = 1'b0, cfg_sync_rise = 1'b1;
  logic [DIV_W-1:0]  cfg_us_div = '0;
  logic [TIME_W-1:0] cfg_period = 16'd4;
  logic [TIME_W-1:0] cfg_ctl_start = '0, cfg_ctl_width = '0;
  logic              cfg_ctl_low = 1'b0;
  logic [TIME_W-1:0] cfg_div_start = '0, cfg_div_interval = '0;
  logic [CNT_W-1:0]  cfg_div_count = '0;
  logic              cfg_div_low = 1'b0;
  logic cycle_start, ctl_clk, div_clk;

  always #4 clk = ~clk;

  cycle_timer_top u0 (
    .clk(clk), .rst(rst), .sync_in(sync_in), .cfg_ext_sync(cfg_ext_sync),
    .cfg_sync_rise(cfg_sync_rise), .cfg_us_div(cfg_us_div), .cfg_period(cfg_period),
    .cfg_ctl_start(cfg_ctl_start), .cfg_ctl_width(cfg_ctl_width),
    .cfg_ctl_low(cfg_ctl_low), .cfg_div_start(cfg_div_start),
    .cfg_div_count(cfg_div_count), .cfg_div_interval(cfg_div_interval),
    .cfg_div_low(cfg_div_low), .cycle_start(cycle_start), .ctl_clk(ctl_clk),
    .div_clk(div_clk)
  );

  int vecs = 0, errs = 0;
  bit done = 0;
  // model state: settings captured at the last cycle start
  int cD, cP, cCS, cCW, cCL, cDS, cDN, cDI, cDL;
  int kk;
  bit boot;
  bit [2:0] sh;
  bit sync_prev;

  task automatic chk(input string tag, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    cD = 0; cP = 0; cCS = 0; cCW = 0; cCL = 0; cDS = 0; cDN = 0; cDI = 0; cDL = 0;
    kk = 0; boot = 1; sh = '0;
  endtask

  // one clock: sample away from the rising edge, compare with the model
  task automatic step();
    int u, ie, dp1;
    bit exp_cs, c_on, d_on;
    @(posedge clk);
    @(negedge clk);
    dp1 = cD + 1;
    if (boot) exp_cs = 1;
    else if (cfg_ext_sync) exp_cs = sh[2];
    else exp_cs = (kk + 1 == cP * dp1);
    u = kk / dp1;
    c_on = (u >= cCS) && (u < cCS + cCW);
    ie = (cDI == 0) ? 1 : cDI;
    d_on = (u >= cDS) && (((u - cDS) % ie) == 0) && (((u - cDS) / ie) < cDN);
    chk(cfg_ext_sync ? "R2 R10 cycle_start" : "R3 R1 R10 cycle_start", cycle_start, exp_cs);
    chk("R4/R5/R1/R8/R9 ctl_clk", ctl_clk, c_on ^ cCL[0]);
    chk("R6/R7/R1/R8/R9 div_clk", div_clk, d_on ^ cDL[0]);
    kk++;
    if (exp_cs) begin
      kk = 0; boot = 0;
      cD = int'(cfg_us_div); cP = int'(cfg_period);
      cCS = int'(cfg_ctl_start); cCW = int'(cfg_ctl_width); cCL = int'(cfg_ctl_low);
      cDS = int'(cfg_div_start); cDN = int'(cfg_div_count);
      cDI = int'(cfg_div_interval); cDL = int'(cfg_div_low);
    end
    sh = {sh[1:0], 1'b0};
  endtask

  task automatic drive_sync(input logic v);
    bit act;
    act = cfg_sync_rise ? (!sync_prev && v) : (sync_prev && !v);
    sync_in = v;
    sync_prev = v;
    if (cfg_ext_sync) sh[0] = act;
  endtask

  task automatic rand_cfg();
    cfg_us_div       = DIV_W'($urandom % 4);
    cfg_period       = TIME_W'(3 + $urandom % 18);
    cfg_ctl_start    = TIME_W'($urandom % 6);
    cfg_ctl_width    = TIME_W'($urandom % 6);
    cfg_ctl_low      = 1'($urandom % 2);
    cfg_div_start    = TIME_W'($urandom % 5);
    cfg_div_count    = CNT_W'($urandom % 5);
    cfg_div_interval = TIME_W'($urandom % 4);
    cfg_div_low      = 1'($urandom % 2);
  endtask

  // R10: outputs low during reset; released so that the next sample follows the boot start
  task automatic do_reset(input logic ext, input logic rise, input logic lvl);
    rst = 1'b1;
    cfg_ext_sync = ext; cfg_sync_rise = rise;
    sync_in = lvl; sync_prev = lvl;
    repeat (3) @(negedge clk);
    chk("R10 reset cycle_start", cycle_start, 1'b0);
    chk("R10 reset ctl_clk", ctl_clk, 1'b0);
    chk("R10 reset div_clk", div_clk, 1'b0);
    model_clear();
    rst = 1'b0;
  endtask

  task automatic sync_phase(input logic rise, input logic idle);
    logic lvl;
    rand_cfg();
    do_reset(1'b1, rise, idle);
    lvl = idle;
    for (int p = 0; p < 40; p++) begin
      int gap;
      gap = 3 + int'($urandom % 38);
      for (int g = 0; g < gap; g++) begin
        step();
        if ($urandom % 20 == 0) rand_cfg();
      end
      lvl = ~lvl;
      drive_sync(lvl);
    end
    repeat (10) step();
  endtask

  initial begin
    int seed_val;
    seed_val = int'($urandom(32'd9137));
    model_clear();
    // internal period, random settings rewritten mid-cycle (R3 R9)
    rand_cfg();
    do_reset(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 1500; i++) begin
      step();
      if ($urandom % 25 == 0) rand_cfg();
    end
    // R8: control pulse and burst both longer than the cycle
    cfg_us_div = 0; cfg_period = 4;
    cfg_ctl_start = 2; cfg_ctl_width = 10; cfg_ctl_low = 0;
    cfg_div_start = 1; cfg_div_count = 5; cfg_div_interval = 1; cfg_div_low = 0;
    repeat (40) step();
    // R6: interval 0 acts as 1, divisor 3; R4: width 0 gives no pulse
    cfg_us_div = 3; cfg_period = 9;
    cfg_ctl_start = 0; cfg_ctl_width = 0; cfg_ctl_low = 1;
    cfg_div_start = 2; cfg_div_count = 3; cfg_div_interval = 0; cfg_div_low = 1;
    repeat (120) step();
    // R6: spaced burst, R4: pulse from time zero
    cfg_us_div = 1; cfg_period = 12;
    cfg_ctl_start = 0; cfg_ctl_width = 3; cfg_ctl_low = 0;
    cfg_div_start = 0; cfg_div_count = 4; cfg_div_interval = 3; cfg_div_low = 0;
    repeat (120) step();
    // R2: external sync, rising then falling active edge
    sync_phase(1'b1, 1'b0);
    sync_phase(1'b0, 1'b1);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule